// File: doc/BRIEF.md
# Standard Bank Chunk Decoder

This block decides which of three fixed memory banks answers each CPU memory access. The three banks are the primary bank (Home), the cartridge bank (Dock) and an 8K extension ROM. The 64K address space is cut into eight 8K chunks, and address bits 15:13 give the chunk index. An 8-bit chunk-select register holds one bit per chunk. A clear bit leaves that chunk with the Home bank. A set bit hands the chunk to the alternate bank. A single alternate-choice bit, held in a second I/O port, decides whether that alternate bank is Dock or the extension ROM. Dock and the extension ROM can therefore never both be enabled, because only one of them can be the alternate bank at any time.

Software writes both values through I/O ports, and only the low byte of the address is decoded for them. The chunk-select register sits at port 0xF4. The alternate-choice bit is bit 7 of port 0xFF. Both values can also be read back through the same ports. The outputs are one enable per bank and the 13-bit chunk-local address. The extension ROM is 8K, so it takes that same offset in whichever chunk selects it and appears in every such chunk. An active-low external claim input lets an outside bank take the bus: while it is low, every internal bank enable is held low, whatever the registers contain.

Top module: `chunk_bank_decoder`

## Requirements
- R1: `chunk_idx` equals `cpu_addr[15:13]` and `chunk_offset` equals `cpu_addr[12:0]` at all times. The same offset goes to whichever bank is enabled, so the 8K extension ROM repeats in every chunk that selects it.
- R2: A cycle with `io_wr` high and `cpu_addr[7:0]` equal to 0xF4 loads `io_wdata` into the chunk-select register at that clock edge. Bits 15:8 of the address are ignored. A write to any other low byte leaves the register unchanged.
- R3: For a memory access (`mem_req` high, `ext_claim_n` high), if bit n of the chunk-select register is 0, where n is the chunk index, then `en_home` is high and the other two enables are low.
- R4: If that bit is 1, then `en_dock` is high when the alternate-choice bit is 0, and `en_xrom` is high when it is 1. At most one of the three enables is ever high.
- R5: A cycle with `io_wr` high and `cpu_addr[7:0]` equal to 0xFF stores `io_wdata[7]` as the alternate-choice bit at that clock edge. Data bits 6:0 have no effect.
- R6: While `ext_claim_n` is low, all three bank enables are low, whatever the register contents.
- R7: After reset, the chunk-select register is 0x00 and the alternate-choice bit is 0. Every chunk then enables Home, and Dock is the alternate bank.
- R8: With `io_rd` high, low address byte 0xF4 returns the chunk-select register on `io_rdata`. Low byte 0xFF returns the alternate-choice bit in bit 7 with bits 6:0 zero. In both cases `io_rd_hit` is high. Any other low byte, or `io_rd` low, gives `io_rdata` = 0 and `io_rd_hit` low.
- R9: While `mem_req` is low, all three bank enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address; memory address or I/O port in the low byte |
| mem_req | input | 1 | Memory access in progress |
| io_wr | input | 1 | I/O write strobe, sampled at the clock edge |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| ext_claim_n | input | 1 | Active-low external bank claim; low disables all internal banks |
| io_rdata | output | 8 | I/O read-back data |
| io_rd_hit | output | 1 | High when an I/O read addresses one of the two ports |
| en_home | output | 1 | Home bank enable |
| en_dock | output | 1 | Dock bank enable |
| en_xrom | output | 1 | Extension ROM enable |
| chunk_idx | output | 3 | Chunk index of the current address |
| chunk_offset | output | 13 | Chunk-local address |

## Verification
The hardest case to reach is a chunk whose select bit is set while the alternate-choice bit has just changed. The bank behind that chunk must then flip between Dock and the extension ROM even though the chunk-select register has not been touched. The stimulus reaches this case by loading an alternating select pattern and sweeping all eight chunks. It then toggles the choice bit with data whose low seven bits contradict bit 7, and sweeps again. Finally, a long run of random port writes, reads, accesses and claim pulses is compared every clock against a behavioural model.

// File: rtl/chunkdec_pkg.sv
package chunkdec_pkg;
  localparam int unsigned ADDR_W_DEF = 16;
  localparam int unsigned CHUNK_W_DEF = 3;
  localparam logic [7:0] SEL_PORT_DEF = 8'hF4;
  localparam logic [7:0] CHOICE_PORT_DEF = 8'hFF;

  typedef enum logic [1:0] {
    BANK_NONE = 2'd0,
    BANK_HOME = 2'd1,
    BANK_DOCK = 2'd2,
    BANK_XROM = 2'd3
  } bank_e;
endpackage

// File: rtl/chunkdec_portregs.sv
module chunkdec_portregs #(
  parameter int unsigned DATA_W = 8,
  parameter logic [7:0] SEL_PORT = 8'hF4,
  parameter logic [7:0] CHOICE_PORT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        port_lo,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] sel_q,
  output logic              choice_q
);
  localparam int unsigned CHOICE_BIT = DATA_W - 1;

  function automatic logic port_match(input logic [7:0] lo, input logic [7:0] port);
    return lo == port;
  endfunction

  logic sel_wr_evt;
  logic choice_wr_evt;
  assign sel_wr_evt    = io_wr && port_match(port_lo, SEL_PORT);
  assign choice_wr_evt = io_wr && port_match(port_lo, CHOICE_PORT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      choice_q <= 1'b0;
    end else begin
      if (sel_wr_evt)    sel_q    <= io_wdata;
      if (choice_wr_evt) choice_q <= io_wdata[CHOICE_BIT];
    end
  end

  // R2: a matching write loads the register on the next edge
  p_sel_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr_evt |=> sel_q == $past(io_wdata));
  // R2: without a matching write the register holds
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_wr_evt |=> $stable(sel_q));
  // R5: only the top data bit reaches the choice bit
  p_choice_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    choice_wr_evt |=> choice_q == $past(io_wdata[CHOICE_BIT]));
  p_choice_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !choice_wr_evt |=> $stable(choice_q));
endmodule

// File: rtl/chunkdec_mapper.sv
module chunkdec_mapper
  import chunkdec_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CHUNK_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic                      mem_req,
  input  logic                      ext_claim_n,
  input  logic [(1<<CHUNK_W)-1:0]   sel_q,
  input  logic                      choice_q,
  output logic                      en_home,
  output logic                      en_dock,
  output logic                      en_xrom,
  output logic [CHUNK_W-1:0]        chunk_idx,
  output logic [ADDR_W-CHUNK_W-1:0] chunk_offset
);
  localparam int unsigned NUM_CHUNKS = 1 << CHUNK_W;
  localparam int unsigned OFFSET_W = ADDR_W - CHUNK_W;

  function automatic bank_e pick_bank(input logic access, input logic alt, input logic choice);
    if (!access)     return BANK_NONE;
    else if (!alt)   return BANK_HOME;
    else if (choice) return BANK_XROM;
    else             return BANK_DOCK;
  endfunction

  assign chunk_idx    = cpu_addr[ADDR_W-1 -: CHUNK_W];
  assign chunk_offset = cpu_addr[OFFSET_W-1:0];

  logic [NUM_CHUNKS-1:0] chunk_hit;
  logic [NUM_CHUNKS-1:0] chunk_alt;
  for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
    assign chunk_hit[c] = (chunk_idx == CHUNK_W'(c));
    assign chunk_alt[c] = chunk_hit[c] & sel_q[c];
  end

  logic  access_ok;
  logic  alt_sel;
  bank_e bank;
  assign access_ok = mem_req & ext_claim_n;
  assign alt_sel   = |chunk_alt;
  assign bank      = pick_bank(access_ok, alt_sel, choice_q);

  assign en_home = (bank == BANK_HOME);
  assign en_dock = (bank == BANK_DOCK);
  assign en_xrom = (bank == BANK_XROM);

  // R6: an external claim silences every internal bank
  p_claim_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_claim_n |-> !(en_home || en_dock || en_xrom));
  // R9: no enable without an access
  p_idle_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req |-> !(en_home || en_dock || en_xrom));
  // R4: never two banks at once
  p_single_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({en_home, en_dock, en_xrom}));
  // R3: an unclaimed access always finds a bank
  p_answered_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && ext_claim_n) |-> (en_home || en_dock || en_xrom));
endmodule

// File: rtl/chunkdec_readback.sv
module chunkdec_readback #(
  parameter int unsigned DATA_W = 8,
  parameter logic [7:0] SEL_PORT = 8'hF4,
  parameter logic [7:0] CHOICE_PORT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        port_lo,
  input  logic              io_rd,
  input  logic [DATA_W-1:0] sel_q,
  input  logic              choice_q,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rd_hit
);
  localparam int unsigned CHOICE_BIT = DATA_W - 1;

  function automatic logic [DATA_W-1:0] place_choice(input logic b);
    logic [DATA_W-1:0] v;
    v = '0;
    v[CHOICE_BIT] = b;
    return v;
  endfunction

  logic rd_sel;
  logic rd_choice;
  assign rd_sel    = io_rd && (port_lo == SEL_PORT);
  assign rd_choice = io_rd && (port_lo == CHOICE_PORT);

  always_comb begin
    io_rdata = '0;
    if (rd_sel)         io_rdata = sel_q;
    else if (rd_choice) io_rdata = place_choice(choice_q);
  end
  assign io_rd_hit = rd_sel | rd_choice;

  // R8: no read strobe, quiet bus
  p_rd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> (io_rdata == '0 && !io_rd_hit));
endmodule

// File: rtl/chunk_bank_decoder.sv
module chunk_bank_decoder
  import chunkdec_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned CHUNK_W = CHUNK_W_DEF,
  parameter logic [7:0] SEL_PORT = SEL_PORT_DEF,
  parameter logic [7:0] CHOICE_PORT = CHOICE_PORT_DEF,
  localparam int unsigned DATA_W = 1 << CHUNK_W,
  localparam int unsigned OFFSET_W = ADDR_W - CHUNK_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   cpu_addr,
  input  logic                mem_req,
  input  logic                io_wr,
  input  logic                io_rd,
  input  logic [DATA_W-1:0]   io_wdata,
  input  logic                ext_claim_n,
  output logic [DATA_W-1:0]   io_rdata,
  output logic                io_rd_hit,
  output logic                en_home,
  output logic                en_dock,
  output logic                en_xrom,
  output logic [CHUNK_W-1:0]  chunk_idx,
  output logic [OFFSET_W-1:0] chunk_offset
);
  logic [7:0]        port_lo;
  logic [DATA_W-1:0] sel_q;
  logic              choice_q;

  assign port_lo = cpu_addr[7:0];

  chunkdec_portregs #(
    .DATA_W(DATA_W), .SEL_PORT(SEL_PORT), .CHOICE_PORT(CHOICE_PORT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .port_lo(port_lo), .io_wr(io_wr),
    .io_wdata(io_wdata), .sel_q(sel_q), .choice_q(choice_q)
  );

  chunkdec_mapper #(
    .ADDR_W(ADDR_W), .CHUNK_W(CHUNK_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_req(mem_req),
    .ext_claim_n(ext_claim_n), .sel_q(sel_q), .choice_q(choice_q),
    .en_home(en_home), .en_dock(en_dock), .en_xrom(en_xrom),
    .chunk_idx(chunk_idx), .chunk_offset(chunk_offset)
  );

  chunkdec_readback #(
    .DATA_W(DATA_W), .SEL_PORT(SEL_PORT), .CHOICE_PORT(CHOICE_PORT)
  ) u_rb (
    .clk(clk), .rst_n(rst_n), .port_lo(port_lo), .io_rd(io_rd),
    .sel_q(sel_q), .choice_q(choice_q), .io_rdata(io_rdata), .io_rd_hit(io_rd_hit)
  );

  // R1: index and offset are a straight split of the address
  p_split_r1: assert property (@(posedge clk) disable iff (!rst_n)
    {chunk_idx, chunk_offset} == cpu_addr);
  // R7: registers are clear in the first cycle after reset
  p_reset_clear_r7: assert property (@(posedge clk)
    !rst_n |=> (sel_q == '0 && !choice_q));
endmodule

// File: tb/chunk_bank_decoder_tb.sv
`timescale 1ns/1ps
module chunk_bank_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        mem_req = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic        ext_claim_n = 1'b1;
  logic [7:0]  io_rdata;
  logic        io_rd_hit, en_home, en_dock, en_xrom;
  logic [2:0]  chunk_idx;
  logic [12:0] chunk_offset;

  int tests = 0;
  int fails = 0;
  int m_sel = 0;     // model chunk-select register
  int m_alt = 0;     // model alternate-choice bit

  always #2.5 clk = ~clk;

  chunk_bank_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_req(mem_req),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .ext_claim_n(ext_claim_n),
    .io_rdata(io_rdata), .io_rd_hit(io_rd_hit), .en_home(en_home),
    .en_dock(en_dock), .en_xrom(en_xrom), .chunk_idx(chunk_idx),
    .chunk_offset(chunk_offset)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Compare every output against the model, then let the edge update state.
  task automatic step(input bit mem, input logic [15:0] a, input bit wr, input bit rd,
                      input logic [7:0] wd, input bit claim_n, input string tag);
    int chunk, bitv, lo, eh, ed, ex, erd, ehit;
    @(negedge clk);
    mem_req = mem; cpu_addr = a; io_wr = wr; io_rd = rd; io_wdata = wd;
    ext_claim_n = claim_n;
    #1;
    chunk = int'(a) / 8192;
    bitv  = (m_sel / (1 << chunk)) % 2;
    lo    = int'(a) % 256;
    eh = 0; ed = 0; ex = 0;
    if (mem && claim_n) begin
      if (bitv == 0) eh = 1;
      else if (m_alt == 1) ex = 1;
      else ed = 1;
    end
    chk(chunk_idx == 3'(chunk), "R1", "chunk_idx", int'(chunk_idx), chunk);
    chk(chunk_offset == 13'(int'(a) % 8192), "R1", "chunk_offset",
        int'(chunk_offset), int'(a) % 8192);
    chk(en_home == eh[0], tag, "en_home", int'(en_home), eh);
    chk(en_dock == ed[0], tag, "en_dock", int'(en_dock), ed);
    chk(en_xrom == ex[0], tag, "en_xrom", int'(en_xrom), ex);
    erd = 0; ehit = 0;
    if (rd && lo == 'hF4) begin erd = m_sel; ehit = 1; end
    else if (rd && lo == 'hFF) begin erd = m_alt * 128; ehit = 1; end
    chk(int'(io_rdata) == erd, "R8", "io_rdata", int'(io_rdata), erd);
    chk(io_rd_hit == ehit[0], "R8", "io_rd_hit", int'(io_rd_hit), ehit);
    @(posedge clk);
    if (wr && lo == 'hF4) m_sel = int'(wd);
    if (wr && lo == 'hFF) m_alt = int'(wd[7]);
  endtask

  task automatic sweep(input bit claim_n, input bit mem, input string tag);
    for (int c = 0; c < 8; c++)
      step(mem, 16'(c * 8192 + 37 * c + 5), 1'b0, 1'b0, 8'h00, claim_n, tag);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R7: all chunks on Home after reset
    sweep(1'b1, 1'b1, "R7");
    step(1'b0, 16'h00F4, 1'b0, 1'b1, 8'h00, 1'b1, "R8");
    step(1'b0, 16'h00FF, 1'b0, 1'b1, 8'h00, 1'b1, "R8");
    // R2: load alternating pattern, R4 with Dock as alternate
    step(1'b0, 16'h00F4, 1'b1, 1'b0, 8'hA5, 1'b1, "R2");
    step(1'b0, 16'h00F4, 1'b0, 1'b1, 8'h00, 1'b1, "R2");
    sweep(1'b1, 1'b1, "R4");
    // R5: bit 7 set, low bits clear -> extension ROM
    step(1'b0, 16'h00FF, 1'b1, 1'b0, 8'h80, 1'b1, "R5");
    step(1'b0, 16'h00FF, 1'b0, 1'b1, 8'h00, 1'b1, "R5");
    sweep(1'b1, 1'b1, "R4");
    // R5: low bits set, bit 7 clear -> back to Dock
    step(1'b0, 16'h00FF, 1'b1, 1'b0, 8'h7F, 1'b1, "R5");
    step(1'b0, 16'h00FF, 1'b0, 1'b1, 8'h00, 1'b1, "R5");
    sweep(1'b1, 1'b1, "R4");
    // R2: upper address byte ignored, neighbouring port ignored
    step(1'b0, 16'h12F4, 1'b1, 1'b0, 8'h3C, 1'b1, "R2");
    step(1'b0, 16'h00F5, 1'b1, 1'b0, 8'hFF, 1'b1, "R2");
    step(1'b0, 16'hABF4, 1'b0, 1'b1, 8'h00, 1'b1, "R2");
    step(1'b0, 16'h00F5, 1'b0, 1'b1, 8'h00, 1'b1, "R8");
    sweep(1'b1, 1'b1, "R3");
    // R6: claim line, R9: no access
    step(1'b0, 16'h00FF, 1'b1, 1'b0, 8'hFF, 1'b1, "R5");
    sweep(1'b0, 1'b1, "R6");
    sweep(1'b1, 1'b0, "R9");
    // Random traffic against the model
    for (int i = 0; i < 2000; i++) begin
      logic [15:0] a;
      int r;
      r = int'($urandom_range(0, 9));
      a = 16'($urandom);
      if (r < 2) a[7:0] = 8'hF4;
      else if (r < 4) a[7:0] = 8'hFF;
      step(1'($urandom), a, (r % 3 == 0), (r % 2 == 1), 8'($urandom),
           ($urandom_range(0, 7) != 0), "R3");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule